// File: doc/BRIEF.md
# SDRAM Address Mapper with Open-Row Tracking

This block sits between a stream of 32-bit memory requests and an SDRAM command engine. Each request carries a byte address, a write flag and four byte enables. The block splits the address into bank, row and column fields. The split is set at run time by three inputs: bank count, page size and mapping order. For every request it then issues the command sequence the memory needs. A request that hits an open row gets the access alone. A closed bank gets an activate first. A row conflict gets a precharge, then an activate, then the access.

A table holds one valid flag and one row number per bank, so rows stay open between requests. In bank-interleaved order, a linear walk crosses a page boundary into the next bank, and several banks can be open at once. In row-before-bank order, the walk moves to the next row of the same bank, and only one bank is ever open. A precharge-all input clears the whole table. Commands leave one per cycle on a valid/ready handshake, together with the byte-lane data mask.

Top module: `sdram_addr_map`

## Requirements
- R1: The column is taken from word-address bits starting at byte-address bit 2. Its width is 8 + `cfg_page_i` bits (8 to 11). Byte-address bits [1:0] never reach the address outputs.
- R2: `cfg_banks_i` sets the number of bank bits: 0 gives none (bank output 0), 1 gives one bit, 2 gives two bits.
- R3: With `cfg_order_i` = 0, the bank bits sit directly above the column and the 13 row bits sit above the bank bits.
- R4: With `cfg_order_i` = 1, the 13 row bits sit directly above the column and the bank bits sit above the row.
- R5: Command codes are NOP=0, PRE=1, ACT=2, RD=3, WR=4. A request to an open bank whose row matches gets only RD (read) or WR (write). A request to a closed bank gets ACT with the decoded bank and row, then RD/WR with the decoded column.
- R6: A request to an open bank holding a different row gets PRE on that bank, then ACT, then RD/WR. In order 0, rows in other banks stay open, so later hits to them need no ACT.
- R7: In order 1, a request to a bank other than the one open bank gets PRE on the open bank, then ACT on the requested bank, then the access. An ACT is issued only when no bank is open.
- R8: `dqm_o` bit i is driven high on a write when byte enable i is clear. On a read, every bit of `dqm_o` is driven low.
- R9: Reset and `pre_all_i` close every bank. If `pre_all_i` is asserted in the same cycle an ACT is consumed, the clear wins, and the ACT is issued again.
- R10: Only one request is in flight. `req_ready_o` is low while commands are pending. A command that is not yet accepted holds its code, bank, row and column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_banks_i | input | 2 | Bank-count field (0: 1 bank, 1: 2 banks, 2: 4 banks) |
| cfg_page_i | input | 2 | Page-size field; column width is 8 + value |
| cfg_order_i | input | 1 | 0: bank bits below row; 1: row bits below bank |
| pre_all_i | input | 1 | Close all banks in the table |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | 32 | Byte address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | 4 | Byte enables, one per lane |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command consumed when high with valid |
| cmd_o | output | 3 | Command code (R5) |
| bank_o | output | 2 | Target bank |
| row_o | output | 13 | Row address for ACT |
| col_o | output | 11 | Column for RD/WR |
| dqm_o | output | 4 | Byte-lane data mask |

## Verification
Table clearing can land in the same cycle as table filling. A precharge-all pulse may arrive exactly when an ACT is consumed. The bench provokes this by holding `pre_all_i` high across the edge on which the ACT handshake completes. It judges the result by requiring that the next command is ACT again for the same bank and row, rather than the access. A second overlap is a precharge-all during a stalled command; the checker's stability property leaves that cycle out on purpose.

// File: rtl/sdram_map_pkg.sv
package sdram_map_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;
endpackage

// File: rtl/sdram_addr_decode.sv
module sdram_addr_decode #(
  parameter int ADDR_W    = 32,
  parameter int ROW_W     = 13,
  parameter int COL_MIN_W = 8,
  parameter int BANK_W    = 2,
  localparam int COL_W    = COL_MIN_W + 3,
  localparam int WORD_W   = ADDR_W - 2,
  localparam int SH_W     = $clog2(ADDR_W) + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        banks_i,
  input  logic [1:0]        page_i,
  input  logic              order_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);
  logic [WORD_W-1:0] word, cmask, bmask;
  logic [SH_W-1:0]   cw, nb;

  always_comb begin
    word  = addr_i[ADDR_W-1:2];
    cw    = SH_W'(COL_MIN_W) + SH_W'(page_i);
    nb    = (SH_W'(banks_i) > SH_W'(BANK_W)) ? SH_W'(BANK_W) : SH_W'(banks_i);
    cmask = (WORD_W'(1) << cw) - WORD_W'(1);
    bmask = (WORD_W'(1) << nb) - WORD_W'(1);
    col_o = COL_W'(word & cmask);
    if (!order_i) begin
      bank_o = BANK_W'((word >> cw) & bmask);
      row_o  = ROW_W'(word >> (cw + nb));
    end else begin
      row_o  = ROW_W'(word >> cw);
      bank_o = BANK_W'((word >> (cw + SH_W'(ROW_W))) & bmask);
    end
  end
endmodule

// File: rtl/sdram_open_rows.sv
module sdram_open_rows #(
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 13,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clr_all_i,
  input  logic                             set_i,
  input  logic                             clr_i,
  input  logic [BANK_W-1:0]                bank_i,
  input  logic [ROW_W-1:0]                 row_i,
  output logic [NUM_BANKS-1:0]             vld_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]  rows_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_b;
    assign hit_b = (bank_i == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[b]  <= 1'b0;
        rows_o[b] <= '0;
      end else if (clr_all_i) begin
        vld_o[b]  <= 1'b0;  // global clear has priority
      end else if (set_i && hit_b) begin
        vld_o[b]  <= 1'b1;
        rows_o[b] <= row_i;
      end else if (clr_i && hit_b) begin
        vld_o[b]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_map_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 13,
  parameter int COL_W    = 11,
  parameter int BE_W     = 4,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            order_i,
  input  logic                            req_valid_i,
  output logic                            req_ready_o,
  input  logic                            req_we_i,
  input  logic [BE_W-1:0]                 req_be_i,
  input  logic [BANK_W-1:0]               dec_bank_i,
  input  logic [ROW_W-1:0]                dec_row_i,
  input  logic [COL_W-1:0]                dec_col_i,
  input  logic [NUM_BANKS-1:0]            open_vld_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] open_rows_i,
  output logic                            cmd_valid_o,
  input  logic                            cmd_ready_i,
  output cmd_e                            cmd_o,
  output logic [BANK_W-1:0]               bank_o,
  output logic [ROW_W-1:0]                row_o,
  output logic [COL_W-1:0]                col_o,
  output logic [BE_W-1:0]                 dqm_o,
  output logic                            set_o,
  output logic                            clr_o
);
  logic              busy, hold_we, fire, hit, other;
  logic [BE_W-1:0]   hold_be;
  logic [BANK_W-1:0] hold_bank, victim, tgt;
  logic [ROW_W-1:0]  hold_row;
  logic [COL_W-1:0]  hold_col;
  cmd_e              next_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy      <= 1'b0;
      hold_we   <= 1'b0;
      hold_be   <= '0;
      hold_bank <= '0;
      hold_row  <= '0;
      hold_col  <= '0;
    end else if (req_valid_i && !busy) begin
      busy      <= 1'b1;
      hold_we   <= req_we_i;
      hold_be   <= req_be_i;
      hold_bank <= dec_bank_i;
      hold_row  <= dec_row_i;
      hold_col  <= dec_col_i;
    end else if (fire && (next_cmd == CMD_RD || next_cmd == CMD_WR)) begin
      busy <= 1'b0;
    end
  end

  // Decision re-evaluated every cycle against the live table
  always_comb begin
    hit    = open_vld_i[hold_bank] && (open_rows_i[hold_bank] == hold_row);
    other  = 1'b0;
    victim = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (open_vld_i[i] && (BANK_W'(i) != hold_bank)) begin
        other  = 1'b1;
        victim = BANK_W'(i);
      end
    end
    tgt = hold_bank;
    if (hit) begin
      next_cmd = hold_we ? CMD_WR : CMD_RD;
    end else if (open_vld_i[hold_bank]) begin
      next_cmd = CMD_PRE;
    end else if (order_i && other) begin
      next_cmd = CMD_PRE;
      tgt      = victim;
    end else begin
      next_cmd = CMD_ACT;
    end
  end

  assign req_ready_o = !busy;
  assign cmd_valid_o = busy;
  assign fire        = busy && cmd_ready_i;
  assign cmd_o       = busy ? next_cmd : CMD_NOP;
  assign bank_o      = tgt;
  assign row_o       = hold_row;
  assign col_o       = hold_col;
  assign dqm_o       = hold_we ? ~hold_be : '0;
  assign set_o       = fire && (next_cmd == CMD_ACT);
  assign clr_o       = fire && (next_cmd == CMD_PRE);
endmodule

// File: rtl/sdram_addr_map.sv
module sdram_addr_map
  import sdram_map_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ROW_W     = 13,
  parameter int COL_MIN_W = 8,
  parameter int BANK_W    = 2,
  parameter int BE_W      = 4,
  localparam int COL_W     = COL_MIN_W + 3,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_banks_i,
  input  logic [1:0]        cfg_page_i,
  input  logic              cfg_order_i,
  input  logic              pre_all_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [BE_W-1:0]   req_be_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [BE_W-1:0]   dqm_o
);
  logic [BANK_W-1:0]               dec_bank;
  logic [ROW_W-1:0]                dec_row;
  logic [COL_W-1:0]                dec_col;
  logic [NUM_BANKS-1:0]            open_vld;
  logic [NUM_BANKS-1:0][ROW_W-1:0] open_rows;
  logic                            tbl_set, tbl_clr;
  cmd_e                            cmd;

  sdram_addr_decode #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_MIN_W(COL_MIN_W), .BANK_W(BANK_W)
  ) u_dec (
    .addr_i (req_addr_i),
    .banks_i(cfg_banks_i),
    .page_i (cfg_page_i),
    .order_i(cfg_order_i),
    .bank_o (dec_bank),
    .row_o  (dec_row),
    .col_o  (dec_col)
  );

  sdram_open_rows #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_all_i(pre_all_i),
    .set_i    (tbl_set),
    .clr_i    (tbl_clr),
    .bank_i   (bank_o),
    .row_i    (row_o),
    .vld_o    (open_vld),
    .rows_o   (open_rows)
  );

  sdram_cmd_seq #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BE_W(BE_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .order_i    (cfg_order_i),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_we_i   (req_we_i),
    .req_be_i   (req_be_i),
    .dec_bank_i (dec_bank),
    .dec_row_i  (dec_row),
    .dec_col_i  (dec_col),
    .open_vld_i (open_vld),
    .open_rows_i(open_rows),
    .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i),
    .cmd_o      (cmd),
    .bank_o     (bank_o),
    .row_o      (row_o),
    .col_o      (col_o),
    .dqm_o      (dqm_o),
    .set_o      (tbl_set),
    .clr_o      (tbl_clr)
  );

  assign cmd_o = cmd;
endmodule

// File: rtl/sdram_addr_map_chk.sv
module sdram_addr_map_chk #(
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 13,
  parameter int COL_W    = 11,
  parameter int BE_W     = 4,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_order_i,
  input logic                 pre_all_i,
  input logic                 req_ready_o,
  input logic                 cmd_valid_o,
  input logic                 cmd_ready_i,
  input logic [2:0]           cmd_o,
  input logic [BANK_W-1:0]    bank_o,
  input logic [ROW_W-1:0]     row_o,
  input logic [COL_W-1:0]     col_o,
  input logic [BE_W-1:0]      dqm_o,
  input logic [NUM_BANKS-1:0] open_vld
);
  // R10
  busy_blocks_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !req_ready_o);
  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i && !pre_all_i) |=>
      (cmd_valid_o && $stable(cmd_o) && $stable(bank_o) && $stable(row_o) && $stable(col_o)));
  // R8
  read_mask_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == 3'd3) |-> (dqm_o == '0));
  // R5
  act_on_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == 3'd2) |-> !open_vld[bank_o]);
  // R6
  pre_on_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == 3'd1) |-> open_vld[bank_o]);
  // R7
  single_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_order_i && cmd_valid_o && cmd_o == 3'd2) |-> (open_vld == '0));
  // R9
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_all_i |=> (open_vld == '0));
endmodule

bind sdram_addr_map sdram_addr_map_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BE_W(BE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_order_i(cfg_order_i),
  .pre_all_i  (pre_all_i),
  .req_ready_o(req_ready_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i),
  .cmd_o      (cmd_o),
  .bank_o     (bank_o),
  .row_o      (row_o),
  .col_o      (col_o),
  .dqm_o      (dqm_o),
  .open_vld   (open_vld)
);

// File: tb/sdram_addr_map_bench.sv
`timescale 1ns/1ps
module sdram_addr_map_bench;
  localparam int NOP = 0, PRE = 1, ACT = 2, RD = 3, WR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_banks = 2'd2, cfg_page = 2'd0;
  logic        cfg_order = 1'b0, pre_all = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        cmd_valid, cmd_ready = 1'b1;
  logic [2:0]  cmd;
  logic [1:0]  bank;
  logic [12:0] row;
  logic [10:0] col;
  logic [3:0]  dqm;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_addr_map u_sdram_addr_map (
    .clk_i(clk), .rst_ni(rst_n), .cfg_banks_i(cfg_banks), .cfg_page_i(cfg_page),
    .cfg_order_i(cfg_order), .pre_all_i(pre_all), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_addr_i(req_addr), .req_we_i(req_we),
    .req_be_i(req_be), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_o(cmd), .bank_o(bank), .row_o(row), .col_o(col), .dqm_o(dqm)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic we, input logic [3:0] be);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Check command at this negedge; for ACT check row, for RD/WR check col and mask
  task automatic expect_cmd(input int c, input int b, input int rc, input int m, input string tag);
    chk(cmd_valid && cmd == 3'(c), {tag, " cmd"}, int'(cmd), c);
    chk(bank == 2'(b), {tag, " bank"}, int'(bank), b);
    if (c == ACT) chk(row == 13'(rc), {tag, " row"}, int'(row), rc);
    if (c == RD || c == WR) begin
      chk(col == 11'(rc), {tag, " col"}, int'(col), rc);
      chk(dqm == 4'(m), {tag, " dqm"}, int'(dqm), m);
    end
    @(negedge clk);
  endtask

  task automatic pulse_pre_all();
    pre_all = 1'b1;
    @(negedge clk);
    pre_all = 1'b0;
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R10 reset ready", int'(req_ready), 1);
    chk(cmd_valid == 1'b0 && cmd == 3'(NOP), "R9 reset idle", int'(cmd), NOP);
  endtask

  task automatic t_closed_and_hit();
    issue(32'h10, 1'b0, 4'hF);
    expect_cmd(ACT, 0, 0, 0, "R5 closed act");
    expect_cmd(RD, 0, 4, 0, "R1 R8 read col");
    issue(32'h14, 1'b1, 4'b0101);
    expect_cmd(WR, 0, 5, 4'b1010, "R5 R8 hit write mask");
    chk(req_ready == 1'b1, "R10 idle after access", int'(req_ready), 1);
  endtask

  task automatic t_interleave();
    issue(32'h400, 1'b0, 4'hF);
    expect_cmd(ACT, 1, 0, 0, "R3 page cross next bank");
    expect_cmd(RD, 1, 0, 0, "R3 col reset");
    issue(32'h18, 1'b0, 4'hF);
    expect_cmd(RD, 0, 6, 0, "R6 other bank still open");
  endtask

  task automatic t_conflict();
    issue(32'h1000, 1'b0, 4'hF);
    expect_cmd(PRE, 0, 0, 0, "R6 conflict pre");
    expect_cmd(ACT, 0, 1, 0, "R3 R6 conflict act row");
    expect_cmd(RD, 0, 0, 0, "R6 conflict read");
    issue(32'h404, 1'b1, 4'b1110);
    expect_cmd(WR, 1, 1, 4'b0001, "R6 bank1 kept open");
  endtask

  task automatic t_page3();
    cfg_page = 2'd3;
    pulse_pre_all();
    issue(32'h0002_DFFC, 1'b1, 4'hF);
    expect_cmd(ACT, 2, 5, 0, "R1 R2 page3 act");
    expect_cmd(WR, 2, 11'h7FF, 0, "R1 page3 wide col");
  endtask

  task automatic t_one_bank();
    cfg_banks = 2'd0; cfg_page = 2'd1;
    pulse_pre_all();
    issue(32'h0000_1FFF, 1'b0, 4'hF);
    expect_cmd(ACT, 0, 3, 0, "R2 one bank row");
    expect_cmd(RD, 0, 11'h1FF, 0, "R1 R2 one bank col");
  endtask

  task automatic t_row_first();
    cfg_banks = 2'd2; cfg_page = 2'd0; cfg_order = 1'b1;
    pulse_pre_all();
    issue(32'h0080_1C00, 1'b0, 4'hF);
    expect_cmd(ACT, 1, 7, 0, "R4 order1 act");
    expect_cmd(RD, 1, 0, 0, "R4 order1 read");
    issue(32'h0080_2000, 1'b0, 4'hF);
    expect_cmd(PRE, 1, 0, 0, "R4 next row same bank pre");
    expect_cmd(ACT, 1, 8, 0, "R4 next row act");
    expect_cmd(RD, 1, 0, 0, "R4 next row read");
    issue(32'h0180_0000, 1'b0, 4'hF);
    expect_cmd(PRE, 1, 0, 0, "R7 close other bank");
    expect_cmd(ACT, 3, 0, 0, "R7 open new bank");
    expect_cmd(RD, 3, 0, 0, "R7 access new bank");
  endtask

  task automatic t_pre_all_idle();
    issue(32'h0180_0000, 1'b0, 4'hF);
    expect_cmd(RD, 3, 0, 0, "R5 hit before clear");
    pulse_pre_all();
    issue(32'h0180_0000, 1'b0, 4'hF);
    expect_cmd(ACT, 3, 0, 0, "R9 reopen after clear");
    expect_cmd(RD, 3, 0, 0, "R9 access after clear");
  endtask

  task automatic t_pre_all_same_cycle();
    pulse_pre_all();
    issue(32'h0180_0004, 1'b0, 4'hF);
    pre_all = 1'b1;  // coincides with ACT acceptance
    expect_cmd(ACT, 3, 0, 0, "R9 first act");
    pre_all = 1'b0;
    expect_cmd(ACT, 3, 0, 0, "R9 clear wins act repeated");
    expect_cmd(RD, 3, 1, 0, "R9 access after repeat");
  endtask

  task automatic t_stall();
    cmd_ready = 1'b0;
    issue(32'h0180_0008, 1'b1, 4'b0011);
    for (int i = 0; i < 3; i++) begin
      chk(cmd_valid && cmd == 3'(WR) && col == 11'd2, "R10 stall hold", int'(cmd), WR);
      chk(req_ready == 1'b0, "R10 busy not ready", int'(req_ready), 0);
      @(negedge clk);
    end
    cmd_ready = 1'b1;
    expect_cmd(WR, 3, 2, 4'b1100, "R10 R8 release");
    chk(req_ready == 1'b1 && cmd_valid == 1'b0, "R10 back idle", int'(req_ready), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_closed_and_hit();
    t_interleave();
    t_conflict();
    t_page3();
    t_one_bank();
    t_row_first();
    t_pre_all_idle();
    t_pre_all_same_cycle();
    t_stall();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule